// File: doc/BRIEF.md
# Mode-Selectable Synchronous SRAM Read Output Stage

This block is the read side of a synchronous static RAM whose data pins are shared between reads and writes. On each rising clock edge it captures an address and a small set of active-low controls. It then looks up a word in an internal array and presents that word on the data bus. A separate drive-enable output tells the pad logic when to drive the bus and when to let it float.

Two static mode pins choose one of three read timings. In registered timing the data leaves through a rising-edge output register, one full cycle after the address. In latched timing the data leaves through a falling-edge latch, half a cycle after the address. In flow-through timing the array output goes straight to the bus in the same cycle. The mode is captured while reset is held and stays fixed after that.

Output drive is controlled by three things. A write or a deselect turns the drivers off, at the point the chosen timing defines. An asynchronous output-enable pin can float the bus at any time. An asynchronous sleep pin floats the bus and stops new operations, while the array keeps its contents. Writes reach the array only through a plain write port, which represents the write path that lives elsewhere.

Top module: `sram_read_port`

## Requirements
- R1: The mode pins `modeSel` are sampled on every rising edge while `rstN` is low, and that value is then used until the next reset. The encodings are: 2'b00 flow-through, 2'b01 registered, 2'b10 latched. Changing `modeSel` after reset has no effect on output timing.
- R2: In registered mode, a read whose address is sampled at rising edge n drives that word from edge n+1 until edge n+2.
- R3: In latched mode, a read sampled at rising edge n drives its word from the falling edge that follows edge n. The word holds until the next falling edge, provided the next rising edge also samples a read.
- R4: In flow-through mode, a read sampled at rising edge n drives its word from edge n, combinationally from the array, until edge n+1.
- R5: Operations are decoded at the rising edge. `selN`=0 with `rdWrN`=1 is a read. `selN`=0 with `rdWrN`=0 is a write, which never drives the bus. `selN`=1 is a deselect.
- R6: While `oeN` is 1, `busDrive` is 0 in every mode, with no clock needed.
- R7: In latched and flow-through modes, a rising edge that samples a write or a deselect drops `busDrive` at that same edge.
- R8: In registered mode the drive enable is registered: a write or deselect sampled at edge n floats the bus from edge n+1.
- R9: While `sleep` is 1, `busDrive` is 0 at once. A rising edge that samples `sleep`=1 starts no operation and keeps the captured address. Array contents are preserved through sleep.
- R10: Reads at consecutive rising edges each deliver their word in their own slot, with no idle cycle between them.
- R11: Mode 2'b11 behaves as registered mode and sets `modeErr`. `modeErr` stays set until a reset that samples a valid mode, and it is 0 after any reset with a valid mode.
- R12: `wrEn`=1 at a rising edge stores `wrData` at `wrAddr`. Any read whose word is taken from the array after that edge returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs are sampled on its rising edge |
| rstN | input | 1 | Synchronous active-low reset; the mode is captured while it is low |
| modeSel | input | 2 | Read timing select: 00 flow-through, 01 registered, 10 latched, 11 reserved |
| selN | input | 1 | Active-low select |
| rdWrN | input | 1 | 1 means read, 0 means write, when selected |
| oeN | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous active-high sleep |
| addr | input | ADDR_W | Read address |
| wrEn | input | 1 | Array write strobe |
| wrAddr | input | ADDR_W | Array write address |
| wrData | input | DATA_W | Array write data |
| busData | output | DATA_W | Data presented to the bus pads |
| busDrive | output | 1 | 1 drives the bus, 0 leaves it at high impedance |
| modeErr | output | 1 | Sticky flag: the reserved mode was captured |

## Verification
The hardest situation to reach is in latched mode, where a read follows a write or deselect (or the reverse). Here the falling-edge drive state and the rising-edge operation state overlap for only half a cycle. The bench therefore checks the outputs in both clock phases of every cycle and mixes reads, writes and deselects at random, so that every ordering of a read next to an idle slot appears in each mode. Sleep pulses, output-enable toggles, writes to the address being read, and a change of the mode pins after reset are placed among those reads. Each of them lands in the middle of a pending read rather than on a quiet bus.

// File: rtl/sram_rd_pkg.sv
package sram_rd_pkg;

  typedef enum logic [1:0] {
    MODE_FLOW  = 2'b00,
    MODE_REG   = 2'b01,
    MODE_LATCH = 2'b10,
    MODE_RSVD  = 2'b11
  } rdMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // take a new address at this rising edge
    logic pickFlow;   // output mux: array straight through
    logic pickLatch;  // output mux: falling-edge latch
  } rdStrobe_t;

endpackage

// File: rtl/sram_rd_ctrl.sv
module sram_rd_ctrl
  import sram_rd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       selN,
  input  logic       rdWrN,
  input  logic       oeN,
  input  logic       sleep,
  output rdStrobe_t  strobe,
  output logic       busDrive,
  output logic       modeErr
);

  rdMode_e modeReg;
  logic    rdReg;     // read sampled at the last rising edge
  logic    driveReg;  // registered-mode drive, one edge behind rdReg
  logic    latDrive;  // latched-mode drive, updated on falling edge
  logic    slotOpen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg  <= rdMode_e'(modeSel);
      modeErr  <= (modeSel == 2'b11);
      rdReg    <= 1'b0;
      driveReg <= 1'b0;
    end else begin
      rdReg    <= !sleep && !selN && rdWrN;
      driveReg <= rdReg;
    end
  end

  always_ff @(negedge clk) begin
    if (!rstN) latDrive <= 1'b0;
    else       latDrive <= rdReg;
  end

  always_comb begin
    case (modeReg)
      MODE_FLOW:  slotOpen = rdReg;
      MODE_LATCH: slotOpen = latDrive && rdReg;
      default:    slotOpen = driveReg;
    endcase
  end

  assign busDrive        = slotOpen && !oeN && !sleep;
  assign strobe.capture  = !sleep;
  assign strobe.pickFlow = (modeReg == MODE_FLOW);
  assign strobe.pickLatch = (modeReg == MODE_LATCH);

  // R6: output enable floats the bus
  a_r6_oe_floats: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !busDrive);

  // R9: sleep floats the bus
  a_r9_sleep_floats: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !busDrive);

  // R7: flow and latched modes float as soon as no read is sampled
  a_r7_idle_floats: assert property (@(posedge clk) disable iff (!rstN)
    ((modeReg == MODE_FLOW || modeReg == MODE_LATCH) && !rdReg) |-> !busDrive);

  // R8: registered drive lags the sampled read by one edge
  a_r8_reg_lag: assert property (@(posedge clk) disable iff (!rstN)
    ((modeReg inside {MODE_REG, MODE_RSVD}) && busDrive && $past(rstN))
      |-> $past(rdReg));

  // R1: mode frozen outside reset
  a_r1_mode_frozen: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(modeReg));

  // R11: error flag sticky
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(modeErr)) |-> modeErr);

endmodule

// File: rtl/sram_rd_datapath.sv
module sram_rd_datapath
  import sram_rd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobe_t         strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] busData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] aReg;
  logic [DATA_W-1:0] arrData;
  logic [DATA_W-1:0] qReg;
  logic [DATA_W-1:0] latQ;

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  assign arrData = mem[aReg];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aReg <= '0;
      qReg <= '0;
    end else begin
      if (strobe.capture) aReg <= addr;
      qReg <= arrData;
    end
  end

  always_ff @(negedge clk) begin
    if (!rstN) latQ <= '0;
    else       latQ <= arrData;
  end

  always_comb begin
    if (strobe.pickFlow)       busData = arrData;
    else if (strobe.pickLatch) busData = latQ;
    else                       busData = qReg;
  end

  // R12: a write strobe lands in the array
  a_r12_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (mem[$past(wrAddr)] == $past(wrData)));

  // R9: a sleeping edge keeps the captured address
  a_r9_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.capture && $past(rstN)) |=> $stable(aReg));

endmodule

// File: rtl/sram_read_port.sv
module sram_read_port
  import sram_rd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              selN,
  input  logic              rdWrN,
  input  logic              oeN,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] busData,
  output logic              busDrive,
  output logic              modeErr
);

  rdStrobe_t strobe;

  sram_rd_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .selN     (selN),
    .rdWrN    (rdWrN),
    .oeN      (oeN),
    .sleep    (sleep),
    .strobe   (strobe),
    .busDrive (busDrive),
    .modeErr  (modeErr)
  );

  sram_rd_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .addr    (addr),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .busData (busData)
  );

endmodule

// File: tb/test_sram_read_port.sv
module test_sram_read_port;

  localparam int DW = 16;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    modeSel = 2'b01;
  logic          selN = 1'b1;
  logic          rdWrN = 1'b1;
  logic          oeN = 1'b0;
  logic          sleep = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] busData;
  logic          busDrive;
  logic          modeErr;

  always #4 clk = ~clk;  // 125 MHz

  sram_read_port #(.DATA_W(DW), .ADDR_W(AW)) i_sram_read_port (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .selN(selN), .rdWrN(rdWrN),
    .oeN(oeN), .sleep(sleep), .addr(addr), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .busData(busData), .busDrive(busDrive), .modeErr(modeErr)
  );

  // behavioural reference model
  logic [DW-1:0] mdl [DEPTH];
  int            mM = 1;
  bit            rdS, drvM, latDrvM, errM, armed;
  int            aS;
  logic [DW-1:0] qM, latQM;
  int            compared = 0, mismatched = 0;
  bit            done = 1'b0;

  initial for (int i = 0; i < DEPTH; i++) mdl[i] = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mM = int'(modeSel); errM = (modeSel == 2'b11);
      rdS = 0; drvM = 0; aS = 0; qM = '0; armed = 1;
    end else begin
      qM = mdl[aS];
      drvM = rdS;
      rdS = !sleep && !selN && rdWrN;
      if (!sleep) aS = int'(addr);
    end
    if (wrEn) mdl[wrAddr] = wrData;
  end

  always @(negedge clk) begin
    if (!rstN) begin latDrvM = 0; latQM = '0; end
    else begin latDrvM = rdS; latQM = mdl[aS]; end
  end

  task automatic check(input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic sampleCheck();
    string tag;
    bit expDrive;
    logic [DW-1:0] expData;
    if (!armed || !rstN || done) return;
    case (mM)
      0: begin tag = "R4 R7 R10"; expDrive = rdS; expData = mdl[aS]; end
      2: begin tag = "R3 R7 R10"; expDrive = latDrvM && rdS; expData = latQM; end
      3: begin tag = "R11 R2 R8"; expDrive = drvM; expData = qM; end
      default: begin tag = "R2 R8 R10"; expDrive = drvM; expData = qM; end
    endcase
    if (sleep) tag = {"R9 ", tag};
    else if (oeN) tag = {"R6 ", tag};
    expDrive = expDrive && !oeN && !sleep;
    check({tag, " R5 R1 drive"}, DW'(busDrive), DW'(expDrive));
    if (expDrive) check({tag, " R12 data"}, busData, expData);
    check("R11 modeErr", DW'(modeErr), DW'(errM));
  endtask

  always begin
    @(posedge clk);
    #2 sampleCheck();
    #4 sampleCheck();
  end

  task automatic step();
    @(posedge clk);
    #7;
  endtask

  task automatic idle();
    selN = 1; rdWrN = 1; oeN = 0; sleep = 0; wrEn = 0;
  endtask

  task automatic runMode(input int m);
    rstN = 0; modeSel = 2'(m); idle();
    repeat (3) step();
    rstN = 1;
    step();
    // reset state
    check("R1 reset drive", DW'(busDrive), '0);
    check("R11 reset flag", DW'(modeErr), DW'(m == 3));
    // fill array (R12)
    for (int a = 0; a < DEPTH; a++) begin
      wrEn = 1; wrAddr = AW'(a); wrData = DW'(16'h1000 * (m + 1) + a * 37);
      step();
    end
    wrEn = 0;
    // back-to-back reads (R10)
    for (int a = 1; a < 7; a++) begin
      selN = 0; rdWrN = 1; addr = AW'(a); step();
    end
    // read-write-read, read-deselect-read (R5 R7 R8)
    selN = 0; rdWrN = 0; addr = 4'd9; step();
    selN = 0; rdWrN = 1; addr = 4'd2; step();
    selN = 1; step();
    selN = 0; rdWrN = 1; addr = 4'd7; step();
    // output enable mid read (R6)
    oeN = 1; addr = 4'd8; step();
    oeN = 0; addr = 4'd9; step();
    // sleep during reads (R9)
    sleep = 1; addr = 4'd3; repeat (3) step();
    sleep = 0; addr = 4'd4; step();
    // write to the address being read (R12)
    addr = 4'd4; wrEn = 1; wrAddr = 4'd4; wrData = 16'hbeef; step();
    wrEn = 0; step();
    // mode pins moved after reset (R1)
    modeSel = 2'((m + 1) % 4);
    for (int i = 0; i < 150; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      selN  = (r == 0);
      rdWrN = (r != 1 && r != 2);
      addr  = AW'($urandom_range(0, DEPTH - 1));
      oeN   = ($urandom_range(0, 11) == 0);
      sleep = ($urandom_range(0, 15) == 0);
      wrEn  = ($urandom_range(0, 3) == 0);
      wrAddr = AW'($urandom_range(0, DEPTH - 1));
      wrData = DW'($urandom);
      step();
    end
    idle();
    step();
    check("R11 flag held", DW'(modeErr), DW'(m == 3));
  endtask

  initial begin
    #7;
    for (int m = 0; m < 4; m++) runMode(m);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule